// File: doc/BRIEF.md
# Transmit FIFO with Write-Cycle Request Control

This block is the transmit buffer between a 16-bit host bus and a byte-wide MAC transmit engine. The host writes a word or a single byte per cycle, with an optional end-of-frame flag. The MAC side takes bytes one at a time through a pop port. Space is counted in two-byte slots. Every host write uses one slot, whatever its width. A frame that closes after an odd number of writes is padded by one slot, so that its end lands on a four-byte boundary.

The request output tells the host how many write cycles it can count on, not how many bytes are free. A watermark of 8, 16 or 32 writes sets the level. In non-burst mode the request follows the free space directly. In burst mode the request has hysteresis and stays up until the buffer is almost full. The transmit-start output stays low until a programmable byte threshold is filled or a complete frame is held. Once transmission starts, the request is held low until the MAC reports that the collision window has passed. Writes made while the request is low are still taken if there is room, and each one is confirmed by an acknowledge pulse.

Top module: `txf_tx_fifo`

## Requirements
- R1: After reset the buffer is empty, `host_req` is high, and `mac_valid`, `tx_start`, `host_ack`, `ovf_err` and `udf_err` are low.
- R2: A write that fits is stored, and `host_ack` is high for exactly the cycle after the accepting clock edge. This holds whether `host_req` is high or low.
- R3: A write that does not fit is dropped with no `host_ack`. It sets `ovf_err`, which stays set until reset.
- R4: In non-burst mode (`cfg_burst`=0), `host_req` is high exactly while the free slots number at least W+1. W is 8 for `cfg_wm_sel`=00, 16 for 01, and 32 for 10 or 11. With W=32, continuous word writes into an empty buffer drop the request after the 36th write.
- R5: In burst mode, `host_req` rises once the free slots reach W+1. It then stays high until only 2 or fewer slots are free.
- R6: A write costs one slot. If it carries end-of-frame and is an odd-numbered write of its frame, it costs two slots. The two slots are released when the last byte of that frame is popped.
- R7: `tx_start` rises one clock after twice the used-slot count reaches `cfg_start` (with at least one slot in use), or after a complete frame is held. It stays high until the final byte of a frame is popped. `mac_valid` is only high while `tx_start` is high.
- R8: Bytes leave in write order. A word slot gives bits [7:0] first, then bits [15:8]. A byte slot gives only bits [7:0]. `mac_last` marks the final byte of a frame.
- R9: From the clock on which `tx_start` rises, `host_req` is low. It stays low until a clock edge that samples `slot_passed` high, or until the frame ends.
- R10: A pop while `tx_start` is high and no data is held sets `udf_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write cycle |
| host_data | input | 16 | Write data; only [7:0] is used for a byte write |
| host_is_byte | input | 1 | Write carries one byte |
| host_eof | input | 1 | Write closes the frame |
| host_ack | output | 1 | Write accepted (one-cycle pulse) |
| host_req | output | 1 | Data request to the host |
| cfg_wm_sel | input | 2 | Watermark select: 8, 16, or 32 write cycles |
| cfg_burst | input | 1 | Burst request mode |
| cfg_start | input | 8 | Transmit start threshold in bytes |
| tx_start | output | 1 | Transmission may run |
| slot_passed | input | 1 | Collision window has passed |
| mac_pop | input | 1 | MAC takes one byte |
| mac_valid | output | 1 | A byte is available |
| mac_data | output | 8 | Byte at the head |
| mac_last | output | 1 | Byte ends a frame |
| ovf_err | output | 1 | Sticky: a write was dropped |
| udf_err | output | 1 | Sticky: a pop found no data during transmit |

## Verification
A wrong slot count first shows up at `host_req`. The request falls or rises one write too early or too late around the W+1 and two-slot boundaries. An extra or missing acknowledge appears at the next acceptance near full. A lost pad slot or a wrong release amount shifts every later request edge by one write. A pointer or byte-select fault corrupts the very next byte seen on `mac_data` or the `mac_last` position. A wrong start or hold state shows on `tx_start` or `host_req` within one clock of the threshold crossing or the `slot_passed` pulse.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int HOST_W = 16;

    typedef struct packed {
        logic [HOST_W-1:0] data;
        logic              single;
        logic              eof;
        logic              pad;
    } slot_t;
endpackage

// File: rtl/txf_slot_mem.sv
module txf_slot_mem
    import txf_pkg::*;
#(
    parameter int DEPTH = 68,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  slot_t            wdata,
    input  logic [PTR_W-1:0] raddr,
    output slot_t            rdata
);
    slot_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txf_req_ctrl.sv
module txf_req_ctrl #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] free_slots,
    input  logic [1:0]       wm_sel,
    input  logic             burst,
    input  logic             hold,
    input  logic             latch_q,
    output logic             latch_d,
    output logic             req
);
    logic [CNT_W-1:0] need;
    logic             level_ok;
    logic             burst_on;

    always_comb begin
        unique case (wm_sel)
            2'b00:   need = CNT_W'(9);
            2'b01:   need = CNT_W'(17);
            default: need = CNT_W'(33);
        endcase
        level_ok = free_slots >= need;
        burst_on = latch_q ? (free_slots > CNT_W'(2)) : level_ok;
        latch_d  = burst_on;
        req      = (burst ? burst_on : level_ok) && !hold;
    end
endmodule

// File: rtl/txf_tx_fifo.sv
module txf_tx_fifo
    import txf_pkg::*;
#(
    parameter int SLOTS = 68,
    parameter int THR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_data,
    input  logic              host_is_byte,
    input  logic              host_eof,
    output logic              host_ack,
    output logic              host_req,
    input  logic [1:0]        cfg_wm_sel,
    input  logic              cfg_burst,
    input  logic [THR_W-1:0]  cfg_start,
    output logic              tx_start,
    input  logic              slot_passed,
    input  logic              mac_pop,
    output logic              mac_valid,
    output logic [7:0]        mac_data,
    output logic              mac_last,
    output logic              ovf_err,
    output logic              udf_err
);
    localparam int PTR_W  = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int BYTE_W = CNT_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] used;
        logic [CNT_W-1:0] ent;
        logic [CNT_W-1:0] eofs;
        logic             bsel;
        logic             par;
        logic             go;
        logic             hold;
        logic             ack;
        logic             ovf;
        logic             udf;
        logic             blatch;
    } state_t;

    state_t st_q, st_d;

    slot_t            head;
    slot_t            wslot;
    logic [CNT_W-1:0] free_slots;
    logic [CNT_W-1:0] cost;
    logic [CNT_W-1:0] rel;
    logic [BYTE_W-1:0] fill_bytes;
    logic             acc;
    logic             drop;
    logic             last_in_slot;
    logic             pop_ok;
    logic             pop_slot;
    logic             pop_end;
    logic             latch_d;
    logic             start_hit;
    logic [CNT_W-1:0] used_mon;

    assign free_slots = CNT_W'(SLOTS) - st_q.used;
    assign fill_bytes = {st_q.used, 1'b0};
    assign used_mon   = st_q.used;

    txf_slot_mem #(.DEPTH(SLOTS), .PTR_W(PTR_W)) u_mem (
        .clk   (clk),
        .we    (acc),
        .waddr (st_q.wr_ptr),
        .wdata (wslot),
        .raddr (st_q.rd_ptr),
        .rdata (head)
    );

    txf_req_ctrl #(.CNT_W(CNT_W)) u_req (
        .free_slots (free_slots),
        .wm_sel     (cfg_wm_sel),
        .burst      (cfg_burst),
        .hold       (st_q.hold),
        .latch_q    (st_q.blatch),
        .latch_d    (latch_d),
        .req        (host_req)
    );

    assign mac_valid    = st_q.go && (st_q.ent != '0);
    assign last_in_slot = head.single || st_q.bsel;
    assign mac_data     = st_q.bsel ? head.data[15:8] : head.data[7:0];
    assign mac_last     = mac_valid && head.eof && last_in_slot;
    assign tx_start     = st_q.go;
    assign host_ack     = st_q.ack;
    assign ovf_err      = st_q.ovf;
    assign udf_err      = st_q.udf;

    always_comb begin
        st_d = st_q;

        // write side
        cost  = (host_eof && !st_q.par) ? CNT_W'(2) : CNT_W'(1);
        acc   = host_wr && (free_slots >= cost);
        drop  = host_wr && !acc;
        wslot = '{data: host_data, single: host_is_byte, eof: host_eof,
                  pad: host_eof && !st_q.par};

        // read side
        pop_ok   = mac_pop && mac_valid;
        pop_slot = pop_ok && last_in_slot;
        pop_end  = pop_slot && head.eof;
        rel      = '0;
        if (pop_slot) rel = head.pad ? CNT_W'(2) : CNT_W'(1);

        // counts
        st_d.used = st_q.used + (acc ? cost : '0) - rel;
        if (acc && !pop_slot) st_d.ent = st_q.ent + 1'b1;
        if (!acc && pop_slot) st_d.ent = st_q.ent - 1'b1;
        if (acc && host_eof && !pop_end) st_d.eofs = st_q.eofs + 1'b1;
        if (pop_end && !(acc && host_eof)) st_d.eofs = st_q.eofs - 1'b1;

        // pointers
        if (acc)
            st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(SLOTS - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        if (pop_slot)
            st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(SLOTS - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        if (pop_ok) st_d.bsel = !pop_slot;
        if (acc)    st_d.par  = host_eof ? 1'b0 : !st_q.par;

        // start and collision-window hold
        start_hit = (st_q.eofs != '0) ||
                    ((st_q.used != '0) && (32'(fill_bytes) >= 32'(cfg_start)));
        st_d.go   = st_q.go ? !pop_end : start_hit;
        st_d.hold = (st_d.go && !st_q.go) ||
                    (st_q.hold && !slot_passed && !pop_end);

        // strobes and flags
        st_d.ack    = acc;
        st_d.ovf    = st_q.ovf || drop;
        st_d.udf    = st_q.udf || (mac_pop && st_q.go && (st_q.ent == '0));
        st_d.blatch = latch_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.blatch <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txf_tx_fifo_chk.sv
module txf_tx_fifo_chk #(
    parameter int SLOTS = 68,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_ack,
    input logic             host_req,
    input logic             cfg_burst,
    input logic             tx_start,
    input logic             mac_valid,
    input logic             ovf_err,
    input logic             udf_err,
    input logic [CNT_W-1:0] used_slots
);
    assert_ack_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past(host_wr));

    assert_no_ack_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> !host_ack);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    assert_req_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !cfg_burst) |-> (used_slots <= CNT_W'(SLOTS - 9)));

    assert_burst_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && cfg_burst) |-> (used_slots <= CNT_W'(SLOTS - 3)));

    assert_used_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        used_slots <= CNT_W'(SLOTS));

    assert_valid_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> tx_start);

    assert_hold_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start) |-> !host_req);

    assert_udf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        udf_err |=> udf_err);
endmodule

bind txf_tx_fifo txf_tx_fifo_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_ack   (host_ack),
    .host_req   (host_req),
    .cfg_burst  (cfg_burst),
    .tx_start   (tx_start),
    .mac_valid  (mac_valid),
    .ovf_err    (ovf_err),
    .udf_err    (udf_err),
    .used_slots (used_mon)
);

// File: tb/txf_tx_fifo_tb.sv
`timescale 1ns/1ps
module txf_tx_fifo_tb;
    localparam int SLOTS = 68;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0;
    logic [15:0] host_data = 0;
    logic        host_is_byte = 0;
    logic        host_eof = 0;
    logic        host_ack, host_req;
    logic [1:0]  cfg_wm_sel = 2'b10;
    logic        cfg_burst = 0;
    logic [7:0]  cfg_start = 8'd255;
    logic        tx_start;
    logic        slot_passed = 0;
    logic        mac_pop = 0;
    logic        mac_valid;
    logic [7:0]  mac_data;
    logic        mac_last;
    logic        ovf_err, udf_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    txf_tx_fifo u_dut (.*);

    typedef struct {
        logic [7:0] data;
        bit         last;
        int         rel;
    } exp_byte_t;

    exp_byte_t q[$];
    int  used_m;
    bit  par_m;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0; host_wr = 0; mac_pop = 0;
        repeat (3) tick();
        rst_n = 1;
    endtask

    task automatic wr(input logic [15:0] d, input bit is_byte, input bit eof);
        host_wr = 1; host_data = d; host_is_byte = is_byte; host_eof = eof;
        tick();
        host_wr = 0; host_eof = 0; host_is_byte = 0;
    endtask

    function automatic int cost_of(input bit eof, input bit par);
        return (eof && !par) ? 2 : 1;
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0001_5eed));

        // R1 reset state
        do_reset();
        chk("R1 req", int'(host_req), 1);
        chk("R1 valid", int'(mac_valid), 0);
        chk("R1 start", int'(tx_start), 0);
        chk("R1 ack", int'(host_ack), 0);
        chk("R1 ovf", int'(ovf_err), 0);
        chk("R1 udf", int'(udf_err), 0);

        // R4 W=32 non-burst; R2 writes while req low; R3 overflow
        cfg_wm_sel = 2'b10; cfg_burst = 0; cfg_start = 8'd255;
        do_reset();
        for (int k = 1; k <= 69; k++) begin
            wr(16'(k), 0, 0);
            if (k == 35) chk("R4 req at 35 writes", int'(host_req), 1);
            if (k == 36) chk("R4 req at 36 writes", int'(host_req), 0);
            if (k == 68) chk("R2 ack while req low", int'(host_ack), 1);
            if (k == 69) begin
                chk("R3 no ack on full", int'(host_ack), 0);
                chk("R3 ovf set", int'(ovf_err), 1);
            end
        end
        tick();
        chk("R3 ovf sticky", int'(ovf_err), 1);

        // R4 W=8
        cfg_wm_sel = 2'b00;
        do_reset();
        for (int k = 1; k <= 60; k++) begin
            wr(16'(k), 0, 0);
            if (k == 59) chk("R4 w8 req at 59", int'(host_req), 1);
            if (k == 60) chk("R4 w8 req at 60", int'(host_req), 0);
        end

        // R5 burst with W=16, then drain to the re-assert point
        cfg_wm_sel = 2'b01; cfg_burst = 1; cfg_start = 8'd255;
        do_reset();
        for (int k = 1; k <= 66; k++) begin
            wr(16'(k), 0, 0);
            if (k == 55) chk("R5 burst req past level", int'(host_req), 1);
            if (k == 65) chk("R5 burst req 3 free", int'(host_req), 1);
            if (k == 66) chk("R5 burst req 2 free", int'(host_req), 0);
        end
        cfg_start = 8'd2;
        tick();
        chk("R7 start after threshold", int'(tx_start), 1);
        slot_passed = 1; tick(); slot_passed = 0;
        for (int w = 0; w < 15; w++) begin
            mac_pop = 1; tick(); tick(); mac_pop = 0;
            chk("R5 burst re-assert", int'(host_req), (3 + w >= 17) ? 1 : 0);
        end
        cfg_burst = 0;

        // R7 threshold, R9 hold, R8 order, R10 underflow
        cfg_wm_sel = 2'b00; cfg_start = 8'd8; slot_passed = 0;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            wr(16'hA0B1 + 16'(i * 16'h0101), 0, 0);
            chk("R7 no start below threshold", int'(tx_start), 0);
        end
        tick();
        chk("R7 start at threshold", int'(tx_start), 1);
        chk("R9 req held after start", int'(host_req), 0);
        tick();
        chk("R9 req still held", int'(host_req), 0);
        slot_passed = 1; tick(); slot_passed = 0;
        chk("R9 req after slot time", int'(host_req), 1);
        for (int i = 0; i < 4; i++) begin
            logic [15:0] w;
            w = 16'hA0B1 + 16'(i * 16'h0101);
            chk("R8 low byte first", int'(mac_data), int'(w[7:0]));
            mac_pop = 1; tick(); mac_pop = 0;
            chk("R8 high byte second", int'(mac_data), int'(w[15:8]));
            mac_pop = 1; tick(); mac_pop = 0;
        end
        chk("R8 empty valid", int'(mac_valid), 0);
        chk("R10 no udf yet", int'(udf_err), 0);
        mac_pop = 1; tick(); mac_pop = 0;
        chk("R10 udf set", int'(udf_err), 1);

        // R6 odd frame pads one slot; R8 last on byte slot
        cfg_wm_sel = 2'b00; cfg_start = 8'd255; slot_passed = 1;
        do_reset();
        wr(16'h005A, 1, 1);
        tick(); tick();
        chk("R7 start on full frame", int'(tx_start), 1);
        chk("R8 byte data", int'(mac_data), 32'h5A);
        chk("R8 last on byte", int'(mac_last), 1);
        for (int k = 1; k <= 58; k++) begin
            wr(16'(k), 0, 0);
            if (k == 57) chk("R6 odd frame req at 59 used", int'(host_req), 1);
            if (k == 58) chk("R6 odd frame req at 60 used", int'(host_req), 0);
        end

        // R6 even frame, no pad
        do_reset();
        wr(16'h1111, 0, 0);
        wr(16'h2222, 0, 1);
        tick(); tick();
        for (int k = 1; k <= 58; k++) begin
            wr(16'(k), 0, 0);
            if (k == 57) chk("R6 even frame req at 59 used", int'(host_req), 1);
            if (k == 58) chk("R6 even frame req at 60 used", int'(host_req), 0);
        end

        // random mix: acceptance, slot release and byte order
        cfg_wm_sel = 2'($urandom % 3); cfg_start = 8'd255; slot_passed = 1;
        do_reset();
        q.delete(); used_m = 0; par_m = 0;
        for (int c = 0; c < 4000; c++) begin
            bit do_wr, is_b, eof, do_pop, acc;
            logic [15:0] d;
            int cst;
            do_wr = ($urandom % 3) != 0;
            is_b  = ($urandom % 4) == 0;
            eof   = ($urandom % 8) == 0;
            d     = 16'($urandom);
            do_pop = mac_valid && (($urandom % 2) == 0);
            if (mac_valid && q.size() == 0) chk("R8 valid with no data", 1, 0);
            if (do_pop && q.size() > 0) begin
                chk("R8 random data", int'(mac_data), int'(q[0].data));
                chk("R8 random last", int'(mac_last), int'(q[0].last));
            end
            host_wr = do_wr; host_data = d; host_is_byte = is_b; host_eof = eof;
            mac_pop = do_pop;
            tick();
            host_wr = 0; mac_pop = 0;
            cst = cost_of(eof, par_m);
            acc = do_wr && ((SLOTS - used_m) >= cst);
            chk("R2 random ack", int'(host_ack), int'(acc));
            if (acc) begin
                int r_last;
                r_last = eof ? cst : 1;
                used_m += cst;
                if (is_b) q.push_back('{d[7:0], eof, r_last});
                else begin
                    q.push_back('{d[7:0], 1'b0, 0});
                    q.push_back('{d[15:8], eof, r_last});
                end
                par_m = eof ? 1'b0 : !par_m;
            end
            if (do_pop && q.size() > 0) begin
                used_m -= q[0].rel;
                void'(q.pop_front());
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule